// File: doc/BRIEF.md
# Split Receive Descriptor Writeback Formatter

This block composes the writeback image of an advanced receive descriptor once the data mover has finished filling that descriptor's buffers. It takes the byte counts written into the header buffer (buffer 0) and the packet buffer (buffer 1), the outcome of the header-split decision (split-header flag and header-buffer-overflow flag), the header length, the queue's descriptor mode and an end-of-packet indication. It also takes the packet's parse results (IPv4, IPv6, IPv6 extension headers, layer-4 protocol), the RSS enable, hash and type, and the checksum-control bits. From these it produces the length field, the header-info word, the packet-info word, the status/error word and the shared RSS-hash / IP-identification dword.

The fields are computed combinationally. They are then captured in one register stage under a clock enable and presented with a one-cycle valid strobe. Checksum verification and VLAN extraction are done elsewhere. Their status bits enter as a plain input word and are merged into the status/error word.

Top module: `rxwb_fmt`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is sampled high. When `in_valid` is low, all output fields keep their values whatever the other inputs do. After reset, every output is zero. Reset asserts asynchronously and is released through two clock stages, so inputs are accepted from the third rising edge after `rst_n` rises.
- R2: In split mode (`in_mode` = 1), the length is `in_cnt0 + in_cnt1` (modulo 2^16) when `in_sph` equals `in_hbo`, and `in_cnt1` otherwise.
- R3: In always-split mode (`in_mode` = 2), the length is `in_cnt1` regardless of the flags. It is also `in_cnt1` in one-buffer mode (`in_mode` = 0) and in the reserved code 3, which behaves as one-buffer.
- R4: For an end-of-packet descriptor in modes 1 or 2, the header-info word carries `in_hlen` in bits 14:5 and `in_sph` in bit 15, with bits 4:0 zero. In modes 0 and 3, the header-info word is zero.
- R5: The status/error word always has bit 0 (descriptor done) set. On end of packet it also has bit 1 (end of packet) set, and it carries every bit of `in_ext_status` other than bits 0, 1 and 23. In modes 1 and 2 only, bit 23 of that word carries `in_hbo`.
- R6: A descriptor with `in_eop` low produces a status/error word of exactly 1, and the header-info, packet-info and RSS/IP-ID outputs are zero. Its length still follows R2/R3.
- R7: The packet type is a 7-bit field. Bit 2 is set for IPv6 and bit 3 for IPv6 with extension headers (`in_ip6_ext`); either is reported only when `in_ip6` is set and `in_ip6_filt_dis` is clear, and that case takes precedence over IPv4. Otherwise bit 0 is set when `in_ip4` is set.
- R8: `in_l4` is encoded 0 = none, 1 = TCP, 2 = UDP, 3 = SCTP. TCP sets packet-type bit 4 and UDP sets bit 5, whether or not an IP type was reported. SCTP sets bit 6 only when an IP type bit was reported per R7.
- R9: On end of packet, the packet-info word is the packet type shifted left by 4. It is OR'ed with `in_rss_type` in bits 3:0 only when both `in_pcsd` and `in_rss_en` are set.
- R10: On end of packet, the RSS/IP-ID dword is `in_rss_hash` when `in_pcsd` and `in_rss_en` are both set. Otherwise it is `in_ip_id` zero-extended when `in_pcsd` is clear, `in_ippcse` is set and `in_ip4` is set. In all remaining cases it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs describe a finished descriptor this cycle |
| in_mode | input | 2 | Queue descriptor mode: 0 one-buffer, 1 split, 2 always-split, 3 reserved |
| in_eop | input | 1 | Descriptor is the last of its packet |
| in_cnt0 | input | 16 | Bytes written to the header buffer |
| in_cnt1 | input | 16 | Bytes written to the packet buffer |
| in_sph | input | 1 | Header was split |
| in_hbo | input | 1 | Header did not fit the header buffer |
| in_hlen | input | 10 | Header length to report |
| in_rss_en | input | 1 | RSS result is valid |
| in_rss_hash | input | 32 | RSS hash |
| in_rss_type | input | 4 | RSS type |
| in_pcsd | input | 1 | Packet checksum disabled |
| in_ippcse | input | 1 | IP payload checksum enabled |
| in_ip4 | input | 1 | Packet carries IPv4 |
| in_ip6 | input | 1 | Packet carries IPv6 |
| in_ip6_ext | input | 1 | IPv6 packet has extension headers |
| in_ip6_filt_dis | input | 1 | IPv6 recognition disabled |
| in_l4 | input | 2 | Layer-4 protocol code |
| in_ip_id | input | 16 | IPv4 identification |
| in_ext_status | input | 32 | Status/error bits from checksum and VLAN logic |
| out_valid | output | 1 | Output fields updated this cycle |
| out_len | output | 16 | Length field |
| out_hdr_info | output | 16 | Header-info word |
| out_pkt_info | output | 16 | Packet-info word |
| out_status | output | 32 | Status/error word |
| out_rss_ipid | output | 32 | RSS hash or IP identification |

## Verification
Every field and the valid strobe pass through one register stage, so each result is due at the first rising edge after the edge that samples `in_valid`. The only exception is the asynchronous clear, which is immediate. The bench changes inputs on falling edges and compares each output field at the next falling edge, so each comparison falls one clock after its stimulus. Back-to-back vectors are compared one vector behind the drive. After `rst_n` rises, the bench idles for more than the two synchronizer cycles before it drives valid data. The hold and the asynchronous clear are checked at the falling edge after idle input changes and within the same low clock phase, respectively.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  typedef enum logic [1:0] {
    MODE_ONEBUF       = 2'd0,
    MODE_SPLIT        = 2'd1,
    MODE_SPLIT_ALWAYS = 2'd2,
    MODE_RSVD         = 2'd3
  } rxwb_mode_e;

  typedef enum logic [1:0] {
    L4_NONE = 2'd0,
    L4_TCP  = 2'd1,
    L4_UDP  = 2'd2,
    L4_SCTP = 2'd3
  } rxwb_l4_e;

  // packet type bit positions (decoded by software)
  localparam int PT_W    = 7;
  localparam int PT_IP4  = 0;
  localparam int PT_IP6  = 2;
  localparam int PT_IP6E = 3;
  localparam int PT_TCP  = 4;
  localparam int PT_UDP  = 5;
  localparam int PT_SCTP = 6;
  localparam int PT_SHIFT = 4;

  // status/error word positions
  localparam int ST_DD  = 0;
  localparam int ST_EOP = 1;
  localparam int ST_HBO = 23;

  // header-info word positions
  localparam int HI_HLEN_LSB = 5;
  localparam int HI_SPH      = 15;

endpackage

// File: rtl/rxwb_rst_sync.sv
module rxwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/rxwb_len.sv
module rxwb_len
  import rxwb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] cnt0,
  input  logic [CNT_W-1:0] cnt1,
  input  logic             sph,
  input  logic             hbo,
  output logic [CNT_W-1:0] len
);

  rxwb_mode_e mode_e;

  always_comb begin
    mode_e = rxwb_mode_e'(mode);
    len    = cnt1;
    if (mode_e == MODE_SPLIT && sph == hbo) begin
      len = cnt0 + cnt1;
    end
  end

endmodule

// File: rtl/rxwb_ptype.sv
module rxwb_ptype
  import rxwb_pkg::*;
(
  input  logic            ip4,
  input  logic            ip6,
  input  logic            ip6_ext,
  input  logic            ip6_filt_dis,
  input  logic [1:0]      l4,
  output logic [PT_W-1:0] ptype
);

  logic       ip_seen;
  rxwb_l4_e   l4_e;

  always_comb begin
    ptype   = '0;
    ip_seen = 1'b0;
    l4_e    = rxwb_l4_e'(l4);
    if (ip6 && !ip6_filt_dis) begin
      ip_seen = 1'b1;
      if (ip6_ext) begin
        ptype[PT_IP6E] = 1'b1;
      end else begin
        ptype[PT_IP6] = 1'b1;
      end
    end else if (ip4) begin
      ip_seen       = 1'b1;
      ptype[PT_IP4] = 1'b1;
    end
    case (l4_e)
      L4_TCP:  ptype[PT_TCP] = 1'b1;
      L4_UDP:  ptype[PT_UDP] = 1'b1;
      L4_SCTP: ptype[PT_SCTP] = ip_seen;
      default: ;
    endcase
  end

endmodule

// File: rtl/rxwb_meta.sv
module rxwb_meta
  import rxwb_pkg::*;
#(
  parameter int HLEN_W = 10,
  parameter int HASH_W = 32,
  parameter int IPID_W = 16,
  parameter int RT_W   = 4,
  parameter int ST_W   = 32,
  parameter int HI_W   = 16,
  parameter int PI_W   = 16
) (
  input  logic [1:0]        mode,
  input  logic              eop,
  input  logic              sph,
  input  logic              hbo,
  input  logic [HLEN_W-1:0] hlen,
  input  logic              rss_en,
  input  logic [HASH_W-1:0] rss_hash,
  input  logic [RT_W-1:0]   rss_type,
  input  logic              pcsd,
  input  logic              ippcse,
  input  logic              ip4,
  input  logic [IPID_W-1:0] ip_id,
  input  logic [ST_W-1:0]   ext_status,
  input  logic [PT_W-1:0]   ptype,
  output logic [HI_W-1:0]   hdr_info,
  output logic [PI_W-1:0]   pkt_info,
  output logic [ST_W-1:0]   status,
  output logic [HASH_W-1:0] rss_ipid
);

  localparam logic [ST_W-1:0] OWN_MASK = (ST_W'(1) << ST_DD) |
                                         (ST_W'(1) << ST_EOP) |
                                         (ST_W'(1) << ST_HBO);

  rxwb_mode_e mode_e;
  logic       split_q;
  logic       use_rss;
  logic       use_ipid;

  always_comb begin
    mode_e   = rxwb_mode_e'(mode);
    split_q  = (mode_e == MODE_SPLIT) || (mode_e == MODE_SPLIT_ALWAYS);
    use_rss  = pcsd && rss_en;
    use_ipid = !pcsd && ippcse && ip4;

    // clear everything before composing
    hdr_info = '0;
    pkt_info = '0;
    status   = '0;
    rss_ipid = '0;

    status[ST_DD] = 1'b1;
    if (eop) begin
      status         = status | (ext_status & ~OWN_MASK);
      status[ST_EOP] = 1'b1;
      if (split_q) begin
        status[ST_HBO]                    = hbo;
        hdr_info[HI_HLEN_LSB +: HLEN_W]   = hlen;
        hdr_info[HI_SPH]                  = sph;
      end
      if (use_rss) begin
        rss_ipid           = rss_hash;
        pkt_info[RT_W-1:0] = rss_type;
      end else if (use_ipid) begin
        rss_ipid[IPID_W-1:0] = ip_id;
      end
      pkt_info[PT_SHIFT +: PT_W] = ptype;
    end
  end

endmodule

// File: rtl/rxwb_fmt.sv
module rxwb_fmt
  import rxwb_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HLEN_W      = 10,
  parameter int HASH_W      = 32,
  parameter int IPID_W      = 16,
  parameter int RT_W        = 4,
  parameter int ST_W        = 32,
  parameter int HI_W        = 16,
  parameter int PI_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic              in_eop,
  input  logic [CNT_W-1:0]  in_cnt0,
  input  logic [CNT_W-1:0]  in_cnt1,
  input  logic              in_sph,
  input  logic              in_hbo,
  input  logic [HLEN_W-1:0] in_hlen,
  input  logic              in_rss_en,
  input  logic [HASH_W-1:0] in_rss_hash,
  input  logic [RT_W-1:0]   in_rss_type,
  input  logic              in_pcsd,
  input  logic              in_ippcse,
  input  logic              in_ip4,
  input  logic              in_ip6,
  input  logic              in_ip6_ext,
  input  logic              in_ip6_filt_dis,
  input  logic [1:0]        in_l4,
  input  logic [IPID_W-1:0] in_ip_id,
  input  logic [ST_W-1:0]   in_ext_status,
  output logic              out_valid,
  output logic [CNT_W-1:0]  out_len,
  output logic [HI_W-1:0]   out_hdr_info,
  output logic [PI_W-1:0]   out_pkt_info,
  output logic [ST_W-1:0]   out_status,
  output logic [HASH_W-1:0] out_rss_ipid
);

  localparam int PT_LAST = PT_SHIFT + PT_W;

  logic              rst_q_n;
  logic [CNT_W-1:0]  len_c;
  logic [PT_W-1:0]   ptype_c;
  logic [HI_W-1:0]   hdr_c;
  logic [PI_W-1:0]   pinfo_c;
  logic [ST_W-1:0]   status_c;
  logic [HASH_W-1:0] rssipid_c;

  logic              valid_d;
  logic [CNT_W-1:0]  len_d;
  logic [HI_W-1:0]   hdr_d;
  logic [PI_W-1:0]   pinfo_d;
  logic [ST_W-1:0]   status_d;
  logic [HASH_W-1:0] rssipid_d;
  logic              fld_en;

  rxwb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  rxwb_len #(.CNT_W(CNT_W)) u_len (
    .mode (in_mode),
    .cnt0 (in_cnt0),
    .cnt1 (in_cnt1),
    .sph  (in_sph),
    .hbo  (in_hbo),
    .len  (len_c)
  );

  rxwb_ptype u_ptype (
    .ip4          (in_ip4),
    .ip6          (in_ip6),
    .ip6_ext      (in_ip6_ext),
    .ip6_filt_dis (in_ip6_filt_dis),
    .l4           (in_l4),
    .ptype        (ptype_c)
  );

  rxwb_meta #(
    .HLEN_W (HLEN_W),
    .HASH_W (HASH_W),
    .IPID_W (IPID_W),
    .RT_W   (RT_W),
    .ST_W   (ST_W),
    .HI_W   (HI_W),
    .PI_W   (PI_W)
  ) u_meta (
    .mode       (in_mode),
    .eop        (in_eop),
    .sph        (in_sph),
    .hbo        (in_hbo),
    .hlen       (in_hlen),
    .rss_en     (in_rss_en),
    .rss_hash   (in_rss_hash),
    .rss_type   (in_rss_type),
    .pcsd       (in_pcsd),
    .ippcse     (in_ippcse),
    .ip4        (in_ip4),
    .ip_id      (in_ip_id),
    .ext_status (in_ext_status),
    .ptype      (ptype_c),
    .hdr_info   (hdr_c),
    .pkt_info   (pinfo_c),
    .status     (status_c),
    .rss_ipid   (rssipid_c)
  );

  // next state
  always_comb begin
    valid_d   = in_valid;
    fld_en    = in_valid;
    len_d     = out_len;
    hdr_d     = out_hdr_info;
    pinfo_d   = out_pkt_info;
    status_d  = out_status;
    rssipid_d = out_rss_ipid;
    if (fld_en) begin
      len_d     = len_c;
      hdr_d     = hdr_c;
      pinfo_d   = pinfo_c;
      status_d  = status_c;
      rssipid_d = rssipid_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid    <= 1'b0;
      out_len      <= '0;
      out_hdr_info <= '0;
      out_pkt_info <= '0;
      out_status   <= '0;
      out_rss_ipid <= '0;
    end else begin
      out_valid    <= valid_d;
      out_len      <= len_d;
      out_hdr_info <= hdr_d;
      out_pkt_info <= pinfo_d;
      out_status   <= status_d;
      out_rss_ipid <= rssipid_d;
    end
  end

  initial begin
    if (PT_LAST > PI_W) $error("packet type does not fit packet-info word");
    if (HI_HLEN_LSB + HLEN_W > HI_SPH) $error("header length overlaps split flag");
  end

endmodule

// File: rtl/rxwb_fmt_chk.sv
module rxwb_fmt_chk #(
  parameter int CNT_W  = 16,
  parameter int HASH_W = 32,
  parameter int ST_W   = 32,
  parameter int HI_W   = 16,
  parameter int PI_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_mode,
  input logic              in_eop,
  input logic [CNT_W-1:0]  in_cnt1,
  input logic              in_hbo,
  input logic              out_valid,
  input logic [CNT_W-1:0]  out_len,
  input logic [HI_W-1:0]   out_hdr_info,
  input logic [PI_W-1:0]   out_pkt_info,
  input logic [ST_W-1:0]   out_status,
  input logic [HASH_W-1:0] out_rss_ipid
);

  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R1
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_len) && $stable(out_status) && $stable(out_rss_ipid))); // R1
  AST_ALWAYS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd2) |=> (out_len == $past(in_cnt1))); // R3
  AST_ONEBUF_NOHDR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_mode == 2'd0 || in_mode == 2'd3)) |=> (out_hdr_info == '0)); // R4
  AST_DD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_status[0]); // R5
  AST_HBO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && (in_mode == 2'd1 || in_mode == 2'd2)) |=> (out_status[23] == $past(in_hbo))); // R5
  AST_NONEOP_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_eop) |=> (out_status == ST_W'(1) && out_hdr_info == '0 &&
                               out_pkt_info == '0 && out_rss_ipid == '0)); // R6

endmodule

bind rxwb_fmt rxwb_fmt_chk #(
  .CNT_W  (CNT_W),
  .HASH_W (HASH_W),
  .ST_W   (ST_W),
  .HI_W   (HI_W),
  .PI_W   (PI_W)
) u_rxwb_fmt_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .in_valid     (in_valid),
  .in_mode      (in_mode),
  .in_eop       (in_eop),
  .in_cnt1      (in_cnt1),
  .in_hbo       (in_hbo),
  .out_valid    (out_valid),
  .out_len      (out_len),
  .out_hdr_info (out_hdr_info),
  .out_pkt_info (out_pkt_info),
  .out_status   (out_status),
  .out_rss_ipid (out_rss_ipid)
);

// File: tb/rxwb_fmt_bench.sv
module rxwb_fmt_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NV         = 9;

  typedef struct packed {
    logic [1:0]  mode;
    logic        eop;
    logic [15:0] cnt0;
    logic [15:0] cnt1;
    logic        sph;
    logic        hbo;
    logic [9:0]  hlen;
    logic        rss_en;
    logic [31:0] hash;
    logic [3:0]  rtype;
    logic        pcsd;
    logic        ippcse;
    logic        ip4;
    logic        ip6;
    logic        ip6e;
    logic        filt;
    logic [1:0]  l4;
    logic [15:0] ipid;
    logic [31:0] ext;
    logic [15:0] exp_len;
    logic [15:0] exp_pkt;
  } vec_t;

  // V0 R2 sum, IPv4 TCP, IP-ID; V1 R2 sph-only, IPv6 UDP, RSS; V2 R2 both set, IPv6E SCTP;
  // V3 R2 hbo-only, filter picks IPv4 + SCTP; V4 R3 always-split, SCTP without IP, ext bits;
  // V5 R3 one-buffer, TCP without IP; V6 R6 split non-EOP; V7 R6 always-split non-EOP;
  // V8 R3 reserved mode, IPv4 UDP, IP-ID while RSS on but checksum not disabled
  localparam vec_t VECS [NV] = '{
    '{mode:2'd1, eop:1'b1, cnt0:16'd10, cnt1:16'd100, sph:1'b0, hbo:1'b0, hlen:10'd54,
      rss_en:1'b0, hash:32'h0, rtype:4'h0, pcsd:1'b0, ippcse:1'b1, ip4:1'b1, ip6:1'b0,
      ip6e:1'b0, filt:1'b0, l4:2'd1, ipid:16'h1234, ext:32'h0, exp_len:16'd110, exp_pkt:16'h0110},
    '{mode:2'd1, eop:1'b1, cnt0:16'd42, cnt1:16'd200, sph:1'b1, hbo:1'b0, hlen:10'd20,
      rss_en:1'b1, hash:32'hDEADBEEF, rtype:4'h2, pcsd:1'b1, ippcse:1'b0, ip4:1'b0, ip6:1'b1,
      ip6e:1'b0, filt:1'b0, l4:2'd2, ipid:16'h0, ext:32'h0, exp_len:16'd200, exp_pkt:16'h0242},
    '{mode:2'd1, eop:1'b1, cnt0:16'd64, cnt1:16'd300, sph:1'b1, hbo:1'b1, hlen:10'd1023,
      rss_en:1'b1, hash:32'h0BADF00D, rtype:4'h5, pcsd:1'b0, ippcse:1'b1, ip4:1'b0, ip6:1'b1,
      ip6e:1'b1, filt:1'b0, l4:2'd3, ipid:16'h7777, ext:32'h0, exp_len:16'd364, exp_pkt:16'h0480},
    '{mode:2'd1, eop:1'b1, cnt0:16'd5, cnt1:16'd77, sph:1'b0, hbo:1'b1, hlen:10'd14,
      rss_en:1'b0, hash:32'h11111111, rtype:4'hF, pcsd:1'b1, ippcse:1'b1, ip4:1'b1, ip6:1'b1,
      ip6e:1'b0, filt:1'b1, l4:2'd3, ipid:16'h2222, ext:32'h0, exp_len:16'd77, exp_pkt:16'h0410},
    '{mode:2'd2, eop:1'b1, cnt0:16'd20, cnt1:16'd500, sph:1'b0, hbo:1'b0, hlen:10'd128,
      rss_en:1'b0, hash:32'h0, rtype:4'h0, pcsd:1'b0, ippcse:1'b0, ip4:1'b0, ip6:1'b1,
      ip6e:1'b0, filt:1'b1, l4:2'd3, ipid:16'h0, ext:32'hFFFFFFFF, exp_len:16'd500, exp_pkt:16'h0000},
    '{mode:2'd0, eop:1'b1, cnt0:16'd9, cnt1:16'd60, sph:1'b1, hbo:1'b1, hlen:10'd33,
      rss_en:1'b0, hash:32'h0, rtype:4'h0, pcsd:1'b0, ippcse:1'b0, ip4:1'b0, ip6:1'b1,
      ip6e:1'b0, filt:1'b1, l4:2'd1, ipid:16'h0, ext:32'h00000004, exp_len:16'd60, exp_pkt:16'h0100},
    '{mode:2'd1, eop:1'b0, cnt0:16'd30, cnt1:16'd40, sph:1'b0, hbo:1'b0, hlen:10'd40,
      rss_en:1'b1, hash:32'h12345678, rtype:4'h1, pcsd:1'b1, ippcse:1'b1, ip4:1'b1, ip6:1'b0,
      ip6e:1'b0, filt:1'b0, l4:2'd1, ipid:16'h9999, ext:32'hFFFFFFFF, exp_len:16'd70, exp_pkt:16'h0000},
    '{mode:2'd2, eop:1'b0, cnt0:16'd64, cnt1:16'd1000, sph:1'b1, hbo:1'b1, hlen:10'd64,
      rss_en:1'b0, hash:32'h0, rtype:4'h0, pcsd:1'b0, ippcse:1'b1, ip4:1'b1, ip6:1'b0,
      ip6e:1'b0, filt:1'b0, l4:2'd2, ipid:16'h4444, ext:32'hFFFFFFFF, exp_len:16'd1000, exp_pkt:16'h0000},
    '{mode:2'd3, eop:1'b1, cnt0:16'd7, cnt1:16'd8, sph:1'b0, hbo:1'b0, hlen:10'd99,
      rss_en:1'b1, hash:32'hCAFECAFE, rtype:4'h7, pcsd:1'b0, ippcse:1'b1, ip4:1'b1, ip6:1'b0,
      ip6e:1'b0, filt:1'b0, l4:2'd2, ipid:16'hBEEF, ext:32'h0, exp_len:16'd8, exp_pkt:16'h0210}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_mode;
  logic        in_eop;
  logic [15:0] in_cnt0;
  logic [15:0] in_cnt1;
  logic        in_sph;
  logic        in_hbo;
  logic [9:0]  in_hlen;
  logic        in_rss_en;
  logic [31:0] in_rss_hash;
  logic [3:0]  in_rss_type;
  logic        in_pcsd;
  logic        in_ippcse;
  logic        in_ip4;
  logic        in_ip6;
  logic        in_ip6_ext;
  logic        in_ip6_filt_dis;
  logic [1:0]  in_l4;
  logic [15:0] in_ip_id;
  logic [31:0] in_ext_status;
  logic        out_valid;
  logic [15:0] out_len;
  logic [15:0] out_hdr_info;
  logic [15:0] out_pkt_info;
  logic [31:0] out_status;
  logic [31:0] out_rss_ipid;

  int checks;
  int failures;

  rxwb_fmt u_rxwb_fmt (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_mode         (in_mode),
    .in_eop          (in_eop),
    .in_cnt0         (in_cnt0),
    .in_cnt1         (in_cnt1),
    .in_sph          (in_sph),
    .in_hbo          (in_hbo),
    .in_hlen         (in_hlen),
    .in_rss_en       (in_rss_en),
    .in_rss_hash     (in_rss_hash),
    .in_rss_type     (in_rss_type),
    .in_pcsd         (in_pcsd),
    .in_ippcse       (in_ippcse),
    .in_ip4          (in_ip4),
    .in_ip6          (in_ip6),
    .in_ip6_ext      (in_ip6_ext),
    .in_ip6_filt_dis (in_ip6_filt_dis),
    .in_l4           (in_l4),
    .in_ip_id        (in_ip_id),
    .in_ext_status   (in_ext_status),
    .out_valid       (out_valid),
    .out_len         (out_len),
    .out_hdr_info    (out_hdr_info),
    .out_pkt_info    (out_pkt_info),
    .out_status      (out_status),
    .out_rss_ipid    (out_rss_ipid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_mode         = v.mode;
    in_eop          = v.eop;
    in_cnt0         = v.cnt0;
    in_cnt1         = v.cnt1;
    in_sph          = v.sph;
    in_hbo          = v.hbo;
    in_hlen         = v.hlen;
    in_rss_en       = v.rss_en;
    in_rss_hash     = v.hash;
    in_rss_type     = v.rtype;
    in_pcsd         = v.pcsd;
    in_ippcse       = v.ippcse;
    in_ip4          = v.ip4;
    in_ip6          = v.ip6;
    in_ip6_ext      = v.ip6e;
    in_ip6_filt_dis = v.filt;
    in_l4           = v.l4;
    in_ip_id        = v.ipid;
    in_ext_status   = v.ext;
  endtask

  function automatic logic is_split(input vec_t v);
    return (v.mode == 2'd1) || (v.mode == 2'd2);
  endfunction

  function automatic logic [15:0] exp_hdr(input vec_t v);
    if (v.eop && is_split(v)) return {v.sph, v.hlen, 5'b0};
    return 16'h0;
  endfunction

  function automatic logic [31:0] exp_status(input vec_t v);
    logic [31:0] s;
    s = 32'h1;
    if (v.eop) begin
      s = s | 32'h2 | (v.ext & ~32'h00800003);
      if (is_split(v) && v.hbo) s = s | 32'h00800000;
    end
    return s;
  endfunction

  function automatic logic [31:0] exp_rss(input vec_t v);
    if (!v.eop) return 32'h0;
    if (v.pcsd && v.rss_en) return v.hash;
    if (!v.pcsd && v.ippcse && v.ip4) return {16'h0, v.ipid};
    return 32'h0;
  endfunction

  task automatic check_vec(input vec_t v);
    chk("R1", "out_valid", {31'b0, out_valid}, 32'h1);
    chk(v.mode == 2'd1 ? "R2" : "R3", "out_len", {16'b0, out_len}, {16'b0, v.exp_len});
    chk(v.eop ? "R4" : "R6", "out_hdr_info", {16'b0, out_hdr_info}, {16'b0, exp_hdr(v)});
    chk(v.eop ? "R5" : "R6", "out_status", out_status, exp_status(v));
    chk(v.eop ? "R9" : "R6", "out_pkt_info", {16'b0, out_pkt_info}, {16'b0, v.exp_pkt});
    chk(v.eop ? "R10" : "R6", "out_rss_ipid", out_rss_ipid, exp_rss(v));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state, even with valid stimulus present
    chk("R1", "reset out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1", "reset out_len", {16'b0, out_len}, 32'h0);
    chk("R1", "reset out_status", out_status, 32'h0);
    chk("R1", "reset out_rss_ipid", out_rss_ipid, 32'h0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after reset out_valid", {31'b0, out_valid}, 32'h0);

    // table walk, back-to-back, checked one vector behind
    for (int i = 0; i < NV; i++) begin
      if (i > 0) check_vec(VECS[i-1]);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
    end
    check_vec(VECS[NV-1]);

    // R1 hold: inputs change with valid low
    in_valid      = 1'b0;
    in_cnt1       = 16'h5555;
    in_cnt0       = 16'h1111;
    in_eop        = 1'b1;
    in_mode       = 2'd1;
    in_ext_status = 32'hFFFFFFFF;
    @(negedge clk);
    chk("R1", "idle out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1", "hold out_len", {16'b0, out_len}, {16'b0, VECS[NV-1].exp_len});
    chk("R1", "hold out_status", out_status, exp_status(VECS[NV-1]));
    chk("R1", "hold out_rss_ipid", out_rss_ipid, exp_rss(VECS[NV-1]));

    // R2 wrap of the summed length
    drive(VECS[0]);
    in_cnt0  = 16'hFFF0;
    in_cnt1  = 16'h0020;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2", "wrapped out_len", {16'b0, out_len}, 32'h0010);

    // R8 UDP reported with no IP type
    drive(VECS[0]);
    in_ip4   = 1'b0;
    in_l4    = 2'd2;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "UDP without IP out_pkt_info", {16'b0, out_pkt_info}, 32'h0200);
    // R7 IPv6 with extension headers, filter off, IPv4 also set
    drive(VECS[0]);
    in_ip6     = 1'b1;
    in_ip6_ext = 1'b1;
    in_l4      = 2'd0;
    in_valid   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "IPv6E over IPv4 out_pkt_info", {16'b0, out_pkt_info}, 32'h0080);
    chk("R10", "IP-ID with IPv4 flag out_rss_ipid", out_rss_ipid, 32'h00001234);

    // R1 asynchronous clear within the low phase
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "async clear out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1", "async clear out_pkt_info", {16'b0, out_pkt_info}, 32'h0);
    chk("R1", "async clear out_hdr_info", {16'b0, out_hdr_info}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule